// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block manages the device side of a single receive descriptor ring held in host memory. Software programs the ring base (address bits 35:8), a ring size code, a buffer size code, a close timeout, a run mode and a write index that marks one entry past the last descriptor it has made ready. The block keeps its own read index. When a frame arrives, it fetches the descriptor at that index and hands the buffer address and length to the receive datapath. When the buffer closes, it asks for a status writeback that carries the index of the filled descriptor, and then it raises an interrupt pulse.

The frame arrival, descriptor fetch and status writeback use valid/ready handshakes. Once the block raises `fetch_valid` or `wb_valid`, it keeps that signal and its payload steady until the matching ready is seen high at a clock edge. Holding ready low stalls the block in that phase for any number of cycles. `frm_ready` only goes high when the channel is running, has no buffer in use and the ring is not empty. Software is expected to move the write index in steps of 8. Equal read and write indices mean that no buffer is available, so at most ring size minus one buffers are ever in use. A tick input marks each 32 µs period for the close timer.

Top module: `rxring_ctrl`

## Requirements
- R1: After reset, `fetch_valid`, `buf_valid`, `wb_valid`, `irq_done` and `irq_tmo` are all 0.
- R2: A fetch request addresses descriptor entry `rd` at `{cfg_ring_base, 8'h00} + 4*rd`, where `rd` is the read index, which starts at 0.
- R3: When the fetch handshake completes, the cycle after it shows `buf_valid`=1, `buf_addr` = `{fetch_desc, 8'h00}`, and `buf_len` = 4096 × (code+1) for `cfg_buf_size` 0..3 (4K, 8K, 12K, 16K).
- R4: `frm_ready` is 0 whenever the read index equals the write index under the ring mask.
- R5: The ring holds 2^L entries, where L is `cfg_ring_log2` clamped to the range 5..12. Only the low L bits of `sw_wr_idx` are compared, and the read index wraps from 2^L−1 to 0.
- R6: The writeback word carries the filled descriptor's index in bits 11:0, with all higher bits 0. The read index advances by one when the writeback handshake completes.
- R7: When `frame_end` is high while a buffer is open, the block moves to writeback in the next cycle. The cycle after the writeback handshake shows `irq_done`=1 and `irq_tmo`=0 for exactly one cycle.
- R8: With `cfg_timeout`=T≠0, an open buffer closes on the T-th tick after it opened, and the cycle after its writeback handshake shows `irq_tmo`=1 and `irq_done`=0. With T=0 the buffer never closes on ticks.
- R9: Run mode 01 (pause at end of frame) leaves an open buffer to finish normally and keeps `frm_ready` at 0.
- R10: Run mode 00 or 11 (off) keeps `frm_ready` at 0. An open buffer is dropped in the next cycle with no writeback and no change to the read index.
- R11: `chan_idle` is 1 exactly when no fetch, buffer or writeback is in progress and the run mode is not 10 (run).
- R12: `fetch_valid` with `fetch_addr`, and `wb_valid` with `wb_data`, stay unchanged until their ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | 28 | Ring base address bits 35:8 |
| cfg_ring_log2 | input | 4 | Ring size code L (2^L entries, clamped 5..12) |
| cfg_buf_size | input | 2 | Buffer size code: 0=4K, 1=8K, 2=12K, 3=16K |
| cfg_run_mode | input | 2 | 00 off, 01 pause at end of frame, 10 run, 11 off |
| cfg_timeout | input | 8 | Close timeout in ticks; 0 disables |
| sw_wr_idx | input | 12 | Software write index (one past the last ready entry) |
| tick_32us | input | 1 | One-cycle pulse every 32 µs |
| frm_valid | input | 1 | A frame needs a buffer |
| frm_ready | output | 1 | The frame is accepted |
| fetch_valid | output | 1 | Descriptor read request |
| fetch_ready | input | 1 | Descriptor read complete; `fetch_desc` valid |
| fetch_addr | output | 36 | Byte address of the descriptor |
| fetch_desc | input | 28 | Descriptor bits 27:0 (buffer address bits 35:8) |
| buf_valid | output | 1 | A buffer is open for the datapath |
| buf_addr | output | 36 | Byte address of the open buffer |
| buf_len | output | 15 | Open buffer length in bytes |
| frame_end | input | 1 | The current frame has finished |
| wb_valid | output | 1 | Status writeback request |
| wb_ready | input | 1 | Status writeback accepted |
| wb_data | output | 32 | Status word; bits 11:0 hold the filled index |
| irq_done | output | 1 | One-cycle pulse: buffer closed by end of frame |
| irq_tmo | output | 1 | One-cycle pulse: buffer closed by timeout |
| chan_idle | output | 1 | The channel has fully stopped |

## Verification
A read index that is off by one, or that wraps wrongly, shows in the next `fetch_addr` and in the next writeback index. The bench drives the ring all the way around its smallest size, so a bad wrap shows within one frame of the wrap point. An error in ring masking or size clamping changes `frm_ready` in the same cycle that the write index or the size code changes. A close timer that counts wrong raises `wb_valid` one tick early or late, and a stop mode that handles state wrongly either leaves `buf_valid` high one cycle after the mode changes or repeats or skips an index on the next fetch.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int IDX_W   = 12;
  localparam int LOG_MIN = 5;
  localparam int LOG_MAX = 12;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_EOF  = 2'b01,
    MODE_RUN  = 2'b10,
    MODE_RSVD = 2'b11
  } run_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_OPEN  = 2'd2,
    ST_WB    = 2'd3
  } ring_state_e;
endpackage

// File: rtl/rxring_index.sv
module rxring_index #(
  parameter int IDX_W   = 12,
  parameter int LOG_MIN = 5,
  parameter int LOG_MAX = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cfg_log2,
  input  logic [IDX_W-1:0] sw_wr_idx,
  input  logic             advance,
  output logic [IDX_W-1:0] rd_idx,
  output logic             avail
);
  logic [3:0]       lg;
  logic [IDX_W:0]   pow;
  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] rd_q;
  logic [IDX_W-1:0] wr_eff;

  always_comb begin
    if (cfg_log2 < 4'(LOG_MIN))      lg = 4'(LOG_MIN);
    else if (cfg_log2 > 4'(LOG_MAX)) lg = 4'(LOG_MAX);
    else                             lg = cfg_log2;
    pow    = (IDX_W+1)'(1) << lg;
    mask   = pow[IDX_W-1:0] - IDX_W'(1);
    rd_idx = rd_q & mask;
    wr_eff = sw_wr_idx & mask;
    avail  = (rd_idx != wr_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_q <= '0;
    else if (advance) rd_q <= (rd_idx + IDX_W'(1)) & mask;
  end
endmodule

// File: rtl/rxring_timer.sv
module rxring_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;
  logic [TMO_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt} + (TMO_W+1)'(1);
  assign expire  = run && tick && (limit != '0) && (cnt_nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n || !run)             cnt <= '0;
    else if (tick && !cnt_nxt[TMO_W]) cnt <= cnt_nxt[TMO_W-1:0];
  end
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
#(
  parameter int BASE_W = 28,
  parameter int ADDR_W = 36,
  parameter int TMO_W  = 8,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] cfg_ring_base,
  input  logic [3:0]        cfg_ring_log2,
  input  logic [1:0]        cfg_buf_size,
  input  logic [1:0]        cfg_run_mode,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic [IDX_W-1:0]  sw_wr_idx,
  input  logic              tick_32us,
  input  logic              frm_valid,
  output logic              frm_ready,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [BASE_W-1:0] fetch_desc,
  output logic              buf_valid,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [14:0]       buf_len,
  input  logic              frame_end,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [STAT_W-1:0] wb_data,
  output logic              irq_done,
  output logic              irq_tmo,
  output logic              chan_idle
);
  localparam int ALIGN_SH = ADDR_W - BASE_W;

  ring_state_e      state;
  logic [IDX_W-1:0] rd_idx;
  logic             avail, advance, expire, stop, tmo_q;
  logic [BASE_W-1:0] desc_q;
  logic [2:0]       len_mult;

  rxring_index #(.IDX_W(IDX_W), .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX)) u_index (
    .clk(clk), .rst_n(rst_n), .cfg_log2(cfg_ring_log2), .sw_wr_idx(sw_wr_idx),
    .advance(advance), .rd_idx(rd_idx), .avail(avail)
  );

  rxring_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_OPEN), .tick(tick_32us),
    .limit(cfg_timeout), .expire(expire)
  );

  assign stop        = (cfg_run_mode == MODE_OFF) || (cfg_run_mode == MODE_RSVD);
  assign frm_ready   = (state == ST_IDLE) && (cfg_run_mode == MODE_RUN) && avail;
  assign fetch_valid = (state == ST_FETCH);
  assign buf_valid   = (state == ST_OPEN);
  assign wb_valid    = (state == ST_WB);
  assign advance     = wb_valid && wb_ready;
  assign chan_idle   = (state == ST_IDLE) && (cfg_run_mode != MODE_RUN);
  assign fetch_addr  = ADDR_W'({cfg_ring_base, {ALIGN_SH{1'b0}}}) + (ADDR_W'(rd_idx) << 2);
  assign buf_addr    = ADDR_W'({desc_q, {ALIGN_SH{1'b0}}});
  assign len_mult    = {1'b0, cfg_buf_size} + 3'd1;
  assign buf_len     = {len_mult, 12'h000};
  assign wb_data     = {{(STAT_W-IDX_W){1'b0}}, rd_idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      desc_q   <= '0;
      tmo_q    <= 1'b0;
      irq_done <= 1'b0;
      irq_tmo  <= 1'b0;
    end else begin
      irq_done <= advance && !tmo_q;
      irq_tmo  <= advance && tmo_q;
      unique case (state)
        ST_IDLE:  if (frm_valid && frm_ready) state <= ST_FETCH;
        ST_FETCH: if (fetch_ready) begin
          desc_q <= fetch_desc;
          state  <= stop ? ST_IDLE : ST_OPEN;
        end
        ST_OPEN: begin
          if (stop) state <= ST_IDLE;
          else if (frame_end) begin
            state <= ST_WB;
            tmo_q <= 1'b0;
          end else if (expire) begin
            state <= ST_WB;
            tmo_q <= 1'b1;
          end
        end
        ST_WB:    if (wb_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr)); // R12
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data)); // R12
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_valid, buf_valid, wb_valid})); // R11
  AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done || irq_tmo) |-> $past(wb_valid && wb_ready)); // R7
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_done && irq_tmo)); // R8
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    chan_idle |-> !frm_ready); // R10
endmodule

// File: tb/rxring_ctrl_bench.sv
module rxring_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] cfg_ring_base = 28'h00ABCDE;
  logic [3:0]  cfg_ring_log2 = 4'd5;
  logic [1:0]  cfg_buf_size = 2'd0;
  logic [1:0]  cfg_run_mode = 2'b10;
  logic [7:0]  cfg_timeout = 8'd0;
  logic [11:0] sw_wr_idx = 12'd0;
  logic        tick_32us = 1'b0, frm_valid = 1'b0, fetch_ready = 1'b0;
  logic        frame_end = 1'b0, wb_ready = 1'b0;
  logic [27:0] fetch_desc = '0;
  logic        frm_ready, fetch_valid, buf_valid, wb_valid, irq_done, irq_tmo, chan_idle;
  logic [35:0] fetch_addr, buf_addr;
  logic [14:0] buf_len;
  logic [31:0] wb_data;

  int n_chk = 0, n_fail = 0;
  int rd_model = 0;
  int ring_size = 32;

  always #10 clk = ~clk;

  rxring_ctrl u_rxring_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_ring_log2(cfg_ring_log2),
    .cfg_buf_size(cfg_buf_size), .cfg_run_mode(cfg_run_mode), .cfg_timeout(cfg_timeout),
    .sw_wr_idx(sw_wr_idx), .tick_32us(tick_32us), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fetch_desc(fetch_desc), .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_len(buf_len),
    .frame_end(frame_end), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .irq_done(irq_done), .irq_tmo(irq_tmo), .chan_idle(chan_idle)
  );

  // {buffer size code, descriptor bits 27:0}
  localparam logic [29:0] VEC [0:7] = '{
    {2'd0, 28'h0000001}, {2'd1, 28'h0FFFFFF}, {2'd2, 28'h1234567}, {2'd3, 28'hFFFFFFF},
    {2'd0, 28'h0000000}, {2'd3, 28'h8000000}, {2'd1, 28'h00A5A5A}, {2'd2, 28'h7654321}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_fetch(input int rd);
    return {cfg_ring_base, 8'h00} + 36'(rd * 4);
  endfunction

  // called at a negedge; leaves the block with an open buffer
  task automatic open_buf(input logic [27:0] desc, input logic [1:0] code);
    logic [35:0] a0;
    cfg_buf_size = code;
    frm_valid = 1'b1;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
    chk(fetch_valid == 1'b1, "R2 fetch_valid", 64'(fetch_valid), 64'd1);
    chk(fetch_addr == exp_fetch(rd_model), "R2 fetch_addr", 64'(fetch_addr), 64'(exp_fetch(rd_model)));
    a0 = fetch_addr;
    @(negedge clk);
    chk(fetch_valid && fetch_addr == a0, "R12 fetch hold", 64'(fetch_addr), 64'(a0));
    fetch_ready = 1'b1;
    fetch_desc = desc;
    @(negedge clk);
    fetch_ready = 1'b0;
    fetch_desc = '0;
    chk(buf_valid == 1'b1, "R3 buf_valid", 64'(buf_valid), 64'd1);
    chk(buf_addr == {desc, 8'h00}, "R3 buf_addr", 64'(buf_addr), 64'({desc, 8'h00}));
    chk(buf_len == 15'((code + 1) * 4096), "R3 buf_len", 64'(buf_len), 64'((code + 1) * 4096));
  endtask

  task automatic finish_wb(input bit by_tmo);
    logic [31:0] d0;
    chk(wb_valid == 1'b1, "R6 wb_valid", 64'(wb_valid), 64'd1);
    chk(wb_data == 32'(rd_model), "R6 wb_data index", 64'(wb_data), 64'(rd_model));
    d0 = wb_data;
    @(negedge clk);
    chk(wb_valid && wb_data == d0, "R12 wb hold", 64'(wb_data), 64'(d0));
    wb_ready = 1'b1;
    @(negedge clk);
    wb_ready = 1'b0;
    if (by_tmo) begin
      chk(irq_tmo == 1'b1 && irq_done == 1'b0, "R8 irq_tmo pulse", 64'({irq_tmo, irq_done}), 64'b10);
    end else begin
      chk(irq_done == 1'b1 && irq_tmo == 1'b0, "R7 irq_done pulse", 64'({irq_tmo, irq_done}), 64'b01);
    end
    rd_model = (rd_model + 1) % ring_size;
    @(negedge clk);
    chk(!irq_done && !irq_tmo, "R7 single pulse", 64'({irq_tmo, irq_done}), 64'd0);
  endtask

  task automatic close_frame();
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    finish_wb(1'b0);
  endtask

  task automatic pulse_tick();
    tick_32us = 1'b1;
    @(negedge clk);
    tick_32us = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({fetch_valid, buf_valid, wb_valid, irq_done, irq_tmo} == 5'b0, "R1 reset outputs",
        64'({fetch_valid, buf_valid, wb_valid, irq_done, irq_tmo}), 64'd0);
    chk(frm_ready == 1'b0, "R4 empty after reset", 64'(frm_ready), 64'd0);
    chk(chan_idle == 1'b0, "R11 running not idle", 64'(chan_idle), 64'd0);

    // table walk: eight frames, then the ring is empty
    sw_wr_idx = 12'd8;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      open_buf(VEC[i][27:0], VEC[i][29:28]);
      close_frame();
    end
    chk(frm_ready == 1'b0, "R4 rd equals wr", 64'(frm_ready), 64'd0);

    // R5 wrap around a 32-entry ring
    sw_wr_idx = 12'd0;
    @(negedge clk);
    chk(frm_ready == 1'b1, "R5 room after wr move", 64'(frm_ready), 64'd1);
    for (int i = 0; i < 24; i++) begin
      open_buf(VEC[i % 8][27:0], VEC[i % 8][29:28]);
      close_frame();
    end
    chk(frm_ready == 1'b0, "R5 wrapped to zero", 64'(frm_ready), 64'd0);

    // R5 clamp and masking
    cfg_ring_log2 = 4'd2;
    sw_wr_idx = 12'd32;
    @(negedge clk);
    chk(frm_ready == 1'b0, "R5 code 2 clamps to 32 entries", 64'(frm_ready), 64'd0);
    cfg_ring_log2 = 4'd6;
    @(negedge clk);
    chk(frm_ready == 1'b1, "R5 64 entries sees wr 32", 64'(frm_ready), 64'd1);
    cfg_ring_log2 = 4'd5;
    sw_wr_idx = 12'd8;
    @(negedge clk);

    // R8 timeout close
    cfg_timeout = 8'd3;
    open_buf(28'h0000042, 2'd0);
    pulse_tick();
    pulse_tick();
    chk(wb_valid == 1'b0 && buf_valid == 1'b1, "R8 still open after 2 ticks",
        64'({wb_valid, buf_valid}), 64'b01);
    tick_32us = 1'b1;
    @(negedge clk);
    tick_32us = 1'b0;
    finish_wb(1'b1);

    // R8 timeout disabled
    cfg_timeout = 8'd0;
    open_buf(28'h0000043, 2'd1);
    for (int i = 0; i < 20; i++) pulse_tick();
    chk(buf_valid == 1'b1 && wb_valid == 1'b0, "R8 zero timeout never closes",
        64'({wb_valid, buf_valid}), 64'b01);
    close_frame();

    // R10 off mode drops open buffer
    open_buf(28'h0000044, 2'd2);
    cfg_run_mode = 2'b00;
    @(negedge clk);
    chk(buf_valid == 1'b0 && wb_valid == 1'b0, "R10 buffer dropped",
        64'({wb_valid, buf_valid}), 64'd0);
    chk(frm_ready == 1'b0, "R10 refuses frames", 64'(frm_ready), 64'd0);
    chk(chan_idle == 1'b1, "R11 idle when off", 64'(chan_idle), 64'd1);
    cfg_run_mode = 2'b11;
    @(negedge clk);
    chk(chan_idle == 1'b1 && frm_ready == 1'b0, "R10 mode 11 acts as off",
        64'({chan_idle, frm_ready}), 64'b10);
    cfg_run_mode = 2'b10;
    @(negedge clk);
    // R10 same index fetched again (checked by R2 inside open_buf)
    chk(fetch_addr == exp_fetch(rd_model), "R10 read index unchanged", 64'(fetch_addr),
        64'(exp_fetch(rd_model)));
    open_buf(28'h0000045, 2'd3);
    close_frame();

    // R9 pause at end of frame
    open_buf(28'h0000046, 2'd0);
    cfg_run_mode = 2'b01;
    @(negedge clk);
    chk(buf_valid == 1'b1, "R9 open buffer kept", 64'(buf_valid), 64'd1);
    chk(chan_idle == 1'b0, "R11 busy while open", 64'(chan_idle), 64'd0);
    close_frame();
    chk(frm_ready == 1'b0, "R9 refuses new frame", 64'(frm_ready), 64'd0);
    chk(chan_idle == 1'b1, "R11 idle after pause", 64'(chan_idle), 64'd1);
    cfg_run_mode = 2'b10;
    @(negedge clk);
    chk(frm_ready == 1'b1 && chan_idle == 1'b0, "R11 resumes", 64'({frm_ready, chan_idle}), 64'b10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule